// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a data cache built from a direct-mapped line array and a small fully associative victim buffer that keeps the lines most recently pushed out of that array. A CPU request is looked up in the direct-mapped array first. A hit there is answered in the next cycle. On a miss the victim buffer is searched. A victim-buffer hit exchanges the buffered line with the line that currently sits in the set, and the request is then served. When both structures miss, the line is fetched from a next-level memory port. The line it displaces from the array enters the victim buffer, and the buffer's oldest entry leaves. If that oldest entry is dirty, it is written back first.

Addresses are word addresses. Bits `[OFFSET_W-1:0]` select the word in a line. The next `INDEX_W` bits select the set, and the remaining upper bits form the tag. The next-level port moves whole lines and addresses them by line address, which is `addr >> OFFSET_W`. Writes allocate on a miss and mark the line dirty. The CPU port handles one request at a time: `req_ready` is high only while the controller is idle.

Top module: `vc_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every line in both structures is invalid, so the first access to any address is fetched from memory.
- R2: A request that hits in the direct-mapped array has `rsp_valid` high in the cycle after the edge that accepts it, and it causes no next-level traffic.
- R3: A read returns the word at its offset within the line. A write stores `req_wdata` into that word, echoes it on `rsp_rdata` and marks the line dirty. A later read of that word returns the written value.
- R4: A request that misses in both structures issues exactly one next-level read, with `mem_req_we` = 0 and `mem_req_addr` = `addr >> OFFSET_W`. The fetched line is installed clean, and the request is then served. Without a write-back the response appears 5 edges after acceptance, counting the accepting edge, when the next level answers one cycle after its request.
- R5: A request that misses in the array but hits in the victim buffer is answered from the buffered line, including any words that were written earlier. It causes no next-level traffic, and its response appears 4 edges after acceptance.
- R6: On a victim-buffer hit, the line previously held by the set moves into the victim slot that was hit. An immediate access to that displaced line is therefore also a victim-buffer hit.
- R7: On a refill, a valid displaced array line is inserted at the victim buffer's FIFO insertion pointer, and the pointer then advances, wrapping after `VB_ENTRIES` entries. Swaps do not move the pointer. The line at the pointer is discarded, so it is the oldest-inserted line that leaves, while younger lines stay hits.
- R8: A dirty line leaving the victim buffer is written to the next level, with `mem_req_we` = 1, its own line address and its full contents, before the refill read is issued. A clean line leaves with no write.
- R9: `req_ready` is 0 in every cycle from the acceptance of a missing request until its response, and `rsp_valid` is only ever high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data, or the written word for writes |
| mem_req_valid | output | 1 | Next-level request, held until accepted |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | ADDR_W-OFFSET_W | Line address |
| mem_req_wline | output | DATA_W<<OFFSET_W | Write-back line contents |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rline | input | DATA_W<<OFFSET_W | Returned line |

## Verification
Lost or duplicated lines inside the cache show at the ports as a changed response latency. A line that should sit in the victim buffer but is missing turns a 4-edge answer into a 5-edge one and adds a next-level read. A line that is wrongly retained hides an expected refill. A dirty bit that is lost shows only when the line later leaves the buffer: the write-back is missing, and a refetch of that line returns stale data, several requests after the fault. A wrong FIFO pointer shows on the first refill that should push out the oldest entry, as a write-back with the wrong line address or as a victim hit on a line that should already be gone.

// File: rtl/vc_cache_pkg.sv
// Package: shared controller state encoding for the victim-buffered cache.
// Assumes nothing beyond standard SystemVerilog enums.
package vc_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_SWAP,
        ST_WBACK,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_REPLAY
    } ctrl_state_e;
endpackage

// File: rtl/vc_dm_array.sv
// Module: direct-mapped line store. One combinational read port and one
// full-line write port. A write always leaves the set valid.
// Assumes: the caller merges partial writes into a full line before writing.
module vc_dm_array #(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 7,
    parameter int LINE_W  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_index,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [LINE_W-1:0]  rd_line,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [LINE_W-1:0]  wr_line,
    input  logic               wr_dirty
);
    localparam int SETS = 1 << INDEX_W;

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    // Valid bits: cleared by reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_index] <= 1'b1;
        end
    end

    // Tag, dirty and data storage: written as a whole line.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_index]   <= wr_tag;
            line_q[wr_index]  <= wr_line;
            dirty_q[wr_index] <= wr_dirty;
        end
    end

    // Read port: asynchronous lookup of the addressed set.
    always_comb begin
        rd_valid = valid_q[rd_index];
        rd_dirty = dirty_q[rd_index];
        rd_tag   = tag_q[rd_index];
        rd_line  = line_q[rd_index];
    end
endmodule

// File: rtl/vc_victim_buf.sv
// Module: fully associative victim buffer. Each entry holds a full line
// address, because its position does not imply a set. It offers an
// associative lookup port, a view of the entry at the FIFO insertion pointer
// and one write port. 'push' advances the pointer after an insertion.
// Assumes: at most one entry matches any line address (the controller never
// inserts a line that is already present).
module vc_victim_buf #(
    parameter int ENTRIES = 4,
    parameter int LADDR_W = 10,
    parameter int LINE_W  = 128,
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LADDR_W-1:0] lk_laddr,
    output logic [ENTRIES-1:0] lk_match,
    output logic               lk_hit,
    output logic [PTR_W-1:0]   lk_slot,
    output logic [LINE_W-1:0]  lk_line,
    output logic               lk_dirty,
    output logic [PTR_W-1:0]   fifo_ptr,
    output logic               ptr_valid,
    output logic               ptr_dirty,
    output logic [LADDR_W-1:0] ptr_laddr,
    output logic [LINE_W-1:0]  ptr_line,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_slot,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [LADDR_W-1:0] wr_laddr,
    input  logic [LINE_W-1:0]  wr_line,
    input  logic               push
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [LADDR_W-1:0] laddr_q [ENTRIES];
    logic [LINE_W-1:0]  line_q  [ENTRIES];
    logic [PTR_W-1:0]   ptr_q;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && (laddr_q[g] == lk_laddr);
    end

    // Encode the matching slot and read its contents.
    always_comb begin
        lk_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) lk_slot = PTR_W'(i);
        end
        lk_hit   = |lk_match;
        lk_line  = line_q[lk_slot];
        lk_dirty = dirty_q[lk_slot];
    end

    // View of the entry that the next insertion will replace.
    always_comb begin
        fifo_ptr  = ptr_q;
        ptr_valid = valid_q[ptr_q];
        ptr_dirty = dirty_q[ptr_q];
        ptr_laddr = laddr_q[ptr_q];
        ptr_line  = line_q[ptr_q];
    end

    // Valid bits and FIFO pointer: reset, written, advanced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (wr_en) valid_q[wr_slot] <= wr_valid;
            if (push) ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Entry payload storage.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            dirty_q[wr_slot] <= wr_dirty;
            laddr_q[wr_slot] <= wr_laddr;
            line_q[wr_slot]  <= wr_line;
        end
    end
endmodule

// File: rtl/vc_cache_ctrl.sv
// Module: request sequencer. It serves array hits at once and otherwise walks
// search, swap, write-back, refill and replay. It drives the write ports of
// both storage structures and the next-level port.
// Assumes: one request in flight; the next level returns a read only after
// accepting it; main_hit is computed against the current line address.
module vc_cache_ctrl
    import vc_cache_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int OFFSET_W = 2,
    parameter int INDEX_W  = 3,
    parameter int VB_PTR_W = 2,
    localparam int LADDR_W = ADDR_W - OFFSET_W,
    localparam int TAG_W   = LADDR_W - INDEX_W,
    localparam int LINE_W  = DATA_W << OFFSET_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_we,
    output logic [LADDR_W-1:0]  mem_req_addr,
    output logic [LINE_W-1:0]   mem_req_wline,
    input  logic                mem_rsp_valid,
    input  logic [LINE_W-1:0]   mem_rsp_rline,
    output logic [LADDR_W-1:0]  cur_laddr,
    input  logic                main_hit,
    input  logic                arr_valid,
    input  logic                arr_dirty,
    input  logic [TAG_W-1:0]    arr_tag,
    input  logic [LINE_W-1:0]   arr_line,
    output logic                arr_wr_en,
    output logic [LINE_W-1:0]   arr_wr_line,
    output logic                arr_wr_dirty,
    input  logic                vb_hit,
    input  logic [VB_PTR_W-1:0] vb_hit_slot,
    input  logic [LINE_W-1:0]   vb_hit_line,
    input  logic                vb_hit_dirty,
    input  logic [VB_PTR_W-1:0] vb_ptr,
    input  logic                vb_ptr_valid,
    input  logic                vb_ptr_dirty,
    input  logic [LADDR_W-1:0]  vb_ptr_laddr,
    input  logic [LINE_W-1:0]   vb_ptr_line,
    output logic                vb_wr_en,
    output logic [VB_PTR_W-1:0] vb_wr_slot,
    output logic                vb_wr_valid,
    output logic                vb_wr_dirty,
    output logic [LADDR_W-1:0]  vb_wr_laddr,
    output logic [LINE_W-1:0]   vb_wr_line,
    output logic                vb_push
);
    ctrl_state_e         state_q, state_d;
    logic                we_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;

    logic [ADDR_W-1:0]   cur_addr;
    logic                cur_we;
    logic [DATA_W-1:0]   cur_wdata;
    logic [OFFSET_W-1:0] cur_off;
    logic [INDEX_W-1:0]  cur_index;
    logic                accept;
    logic                do_access;
    logic                fill_done;
    logic [LINE_W-1:0]   merged_line;
    logic [DATA_W-1:0]   rd_word;

    // Pick the live request: from the port when idle, else the latched copy.
    always_comb begin
        cur_addr  = (state_q == ST_IDLE) ? req_addr  : addr_q;
        cur_we    = (state_q == ST_IDLE) ? req_we    : we_q;
        cur_wdata = (state_q == ST_IDLE) ? req_wdata : wdata_q;
        cur_off   = cur_addr[OFFSET_W-1:0];
        cur_laddr = cur_addr[ADDR_W-1:OFFSET_W];
        cur_index = cur_laddr[INDEX_W-1:0];
    end

    // Handshake and access qualifiers.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        do_access = (accept && main_hit) || (state_q == ST_REPLAY);
        fill_done = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
    end

    // Word select and write merge within the addressed line.
    always_comb begin
        rd_word     = arr_line[cur_off*DATA_W +: DATA_W];
        merged_line = arr_line;
        merged_line[cur_off*DATA_W +: DATA_W] = cur_wdata;
    end

    // Next-state logic of the miss sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (accept && !main_hit) state_d = ST_SEARCH;
            ST_SEARCH: begin
                if (vb_hit)                                       state_d = ST_SWAP;
                else if (arr_valid && vb_ptr_valid && vb_ptr_dirty) state_d = ST_WBACK;
                else                                              state_d = ST_FILL_REQ;
            end
            ST_SWAP:      state_d = ST_REPLAY;
            ST_WBACK:     if (mem_req_ready) state_d = ST_FILL_REQ;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (mem_rsp_valid) state_d = ST_REPLAY;
            ST_REPLAY:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Array write port: store hit, swap-in, or refill install.
    always_comb begin
        arr_wr_en    = 1'b0;
        arr_wr_line  = merged_line;
        arr_wr_dirty = 1'b1;
        if (do_access && cur_we) begin
            arr_wr_en = 1'b1;
        end else if (state_q == ST_SWAP) begin
            arr_wr_en    = 1'b1;
            arr_wr_line  = vb_hit_line;
            arr_wr_dirty = vb_hit_dirty;
        end else if (fill_done) begin
            arr_wr_en    = 1'b1;
            arr_wr_line  = mem_rsp_rline;
            arr_wr_dirty = 1'b0;
        end
    end

    // Victim buffer write port: swap-out into the hit slot, or FIFO insert.
    always_comb begin
        vb_wr_en    = 1'b0;
        vb_wr_slot  = vb_ptr;
        vb_wr_valid = arr_valid;
        vb_wr_dirty = arr_dirty;
        vb_wr_laddr = {arr_tag, cur_index};
        vb_wr_line  = arr_line;
        vb_push     = 1'b0;
        if (state_q == ST_SWAP) begin
            vb_wr_en   = 1'b1;
            vb_wr_slot = vb_hit_slot;
        end else if (fill_done && arr_valid) begin
            vb_wr_en = 1'b1;
            vb_push  = 1'b1;
        end
    end

    // Next-level port: write-back of the outgoing entry, then line read.
    always_comb begin
        mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FILL_REQ);
        mem_req_we    = (state_q == ST_WBACK);
        mem_req_addr  = (state_q == ST_WBACK) ? vb_ptr_laddr : cur_laddr;
        mem_req_wline = vb_ptr_line;
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                we_q    <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Registered response: one pulse per served request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= do_access;
            if (do_access) rsp_rdata <= cur_we ? cur_wdata : rd_word;
        end
    end
endmodule

// File: rtl/vc_cache.sv
// Module: top of the victim-buffered direct-mapped cache. It connects the
// line array, the victim buffer and the sequencer, and forms the array hit.
// Assumes: word addressing, power-of-two line and buffer sizes, and a
// next-level port that transfers full lines.
module vc_cache #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int OFFSET_W   = 2,
    parameter int INDEX_W    = 3,
    parameter int VB_ENTRIES = 4,
    localparam int LADDR_W   = ADDR_W - OFFSET_W,
    localparam int TAG_W     = LADDR_W - INDEX_W,
    localparam int LINE_W    = DATA_W << OFFSET_W,
    localparam int VB_PTR_W  = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_we,
    output logic [LADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0]  mem_req_wline,
    input  logic               mem_rsp_valid,
    input  logic [LINE_W-1:0]  mem_rsp_rline
);
    logic [LADDR_W-1:0]    cur_laddr;
    logic                  main_hit;
    logic                  arr_valid, arr_dirty;
    logic [TAG_W-1:0]      arr_tag;
    logic [LINE_W-1:0]     arr_line;
    logic                  arr_wr_en, arr_wr_dirty;
    logic [LINE_W-1:0]     arr_wr_line;
    logic [VB_ENTRIES-1:0] vb_match;
    logic                  vb_hit, vb_hit_dirty;
    logic [VB_PTR_W-1:0]   vb_hit_slot, vb_ptr;
    logic [LINE_W-1:0]     vb_hit_line, vb_ptr_line;
    logic                  vb_ptr_valid, vb_ptr_dirty;
    logic [LADDR_W-1:0]    vb_ptr_laddr;
    logic                  vb_wr_en, vb_wr_valid, vb_wr_dirty, vb_push;
    logic [VB_PTR_W-1:0]   vb_wr_slot;
    logic [LADDR_W-1:0]    vb_wr_laddr;
    logic [LINE_W-1:0]     vb_wr_line;

    // Array hit: the set is valid and its tag equals the request tag.
    always_comb main_hit = arr_valid && (arr_tag == cur_laddr[LADDR_W-1:INDEX_W]);

    vc_dm_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_index (cur_laddr[INDEX_W-1:0]),
        .rd_valid (arr_valid),
        .rd_dirty (arr_dirty),
        .rd_tag   (arr_tag),
        .rd_line  (arr_line),
        .wr_en    (arr_wr_en),
        .wr_index (cur_laddr[INDEX_W-1:0]),
        .wr_tag   (cur_laddr[LADDR_W-1:INDEX_W]),
        .wr_line  (arr_wr_line),
        .wr_dirty (arr_wr_dirty)
    );

    vc_victim_buf #(.ENTRIES(VB_ENTRIES), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_vbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_laddr  (cur_laddr),
        .lk_match  (vb_match),
        .lk_hit    (vb_hit),
        .lk_slot   (vb_hit_slot),
        .lk_line   (vb_hit_line),
        .lk_dirty  (vb_hit_dirty),
        .fifo_ptr  (vb_ptr),
        .ptr_valid (vb_ptr_valid),
        .ptr_dirty (vb_ptr_dirty),
        .ptr_laddr (vb_ptr_laddr),
        .ptr_line  (vb_ptr_line),
        .wr_en     (vb_wr_en),
        .wr_slot   (vb_wr_slot),
        .wr_valid  (vb_wr_valid),
        .wr_dirty  (vb_wr_dirty),
        .wr_laddr  (vb_wr_laddr),
        .wr_line   (vb_wr_line),
        .push      (vb_push)
    );

    vc_cache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET_W(OFFSET_W),
        .INDEX_W(INDEX_W), .VB_PTR_W(VB_PTR_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_we        (req_we),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wline (mem_req_wline),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rline (mem_rsp_rline),
        .cur_laddr     (cur_laddr),
        .main_hit      (main_hit),
        .arr_valid     (arr_valid),
        .arr_dirty     (arr_dirty),
        .arr_tag       (arr_tag),
        .arr_line      (arr_line),
        .arr_wr_en     (arr_wr_en),
        .arr_wr_line   (arr_wr_line),
        .arr_wr_dirty  (arr_wr_dirty),
        .vb_hit        (vb_hit),
        .vb_hit_slot   (vb_hit_slot),
        .vb_hit_line   (vb_hit_line),
        .vb_hit_dirty  (vb_hit_dirty),
        .vb_ptr        (vb_ptr),
        .vb_ptr_valid  (vb_ptr_valid),
        .vb_ptr_dirty  (vb_ptr_dirty),
        .vb_ptr_laddr  (vb_ptr_laddr),
        .vb_ptr_line   (vb_ptr_line),
        .vb_wr_en      (vb_wr_en),
        .vb_wr_slot    (vb_wr_slot),
        .vb_wr_valid   (vb_wr_valid),
        .vb_wr_dirty   (vb_wr_dirty),
        .vb_wr_laddr   (vb_wr_laddr),
        .vb_wr_line    (vb_wr_line),
        .vb_push       (vb_push)
    );
endmodule

// File: rtl/vc_cache_chk.sv
// Module: protocol and structure checker for vc_cache, attached by bind.
// Assumes: synchronous active-low reset; disabled while reset is low.
module vc_cache_chk #(
    parameter int LADDR_W    = 10,
    parameter int VB_ENTRIES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  rsp_valid,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic                  mem_req_we,
    input logic [LADDR_W-1:0]    mem_req_addr,
    input logic                  main_hit,
    input logic [VB_ENTRIES-1:0] vb_match
);
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && main_hit |=> rsp_valid); // R2
    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R2
    AST_MISS_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !main_hit |=> !req_ready); // R9
    AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R9
    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)); // R4
    AST_VB_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vb_match)); // R7
endmodule

bind vc_cache vc_cache_chk #(.LADDR_W(LADDR_W), .VB_ENTRIES(VB_ENTRIES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .main_hit      (main_hit),
    .vb_match      (vb_match)
);

// File: tb/vc_cache_bench.sv
`timescale 1ns/1ps
module vc_cache_bench;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 2;
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int LN_W   = DATA_W << OFF_W;
    localparam int NLINES = 1 << LA_W;
    localparam int NWORDS = 1 << ADDR_W;

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [3:0]  lat;    // edges from acceptance to response
        logic [1:0]  reads;  // next-level reads expected
        logic [1:0]  wbs;    // next-level writes expected
        logic [3:0]  req;    // requirement number for messages
    } vec_t;

    // Address = tag*32 + set*4 + word. Latency 1 hit, 4 buffer hit, 5 refill, 6 refill with write-back.
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h020, 32'h0,          4'd5, 2'd1, 2'd0, 4'd4}, // R4 cold miss
        '{1'b0, 12'h023, 32'h0,          4'd1, 2'd0, 2'd0, 4'd2}, // R2 hit other word
        '{1'b1, 12'h022, 32'h5EED_0001,  4'd1, 2'd0, 2'd0, 4'd3}, // R3 write hit
        '{1'b0, 12'h022, 32'h0,          4'd1, 2'd0, 2'd0, 4'd3}, // R3 read back
        '{1'b0, 12'h041, 32'h0,          4'd5, 2'd1, 2'd0, 4'd4}, // R4 conflict miss
        '{1'b0, 12'h022, 32'h0,          4'd4, 2'd0, 2'd0, 4'd5}, // R5 dirty line from buffer
        '{1'b0, 12'h040, 32'h0,          4'd4, 2'd0, 2'd0, 4'd6}, // R6 displaced line swapped back
        '{1'b0, 12'h060, 32'h0,          4'd5, 2'd1, 2'd0, 4'd7}, // R7 insert slot 1
        '{1'b0, 12'h080, 32'h0,          4'd5, 2'd1, 2'd0, 4'd7}, // R7 insert slot 2
        '{1'b0, 12'h0A0, 32'h0,          4'd5, 2'd1, 2'd0, 4'd7}, // R7 insert slot 3
        '{1'b0, 12'h0C0, 32'h0,          4'd6, 2'd1, 2'd1, 4'd8}, // R8 dirty oldest written back
        '{1'b0, 12'h022, 32'h0,          4'd5, 2'd1, 2'd0, 4'd7}, // R7 oldest gone, refetch
        '{1'b0, 12'h061, 32'h0,          4'd4, 2'd0, 2'd0, 4'd7}, // R7 younger entry still hits
        '{1'b0, 12'h040, 32'h0,          4'd5, 2'd1, 2'd0, 4'd8}, // R8 clean leave, no write
        '{1'b1, 12'h0F7, 32'h5EED_0002,  4'd5, 2'd1, 2'd0, 4'd3}, // R3 write miss allocates
        '{1'b0, 12'h0F7, 32'h0,          4'd1, 2'd0, 2'd0, 4'd3}  // R3 read after write miss
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic              mem_req_we;
    logic [LA_W-1:0]   mem_req_addr;
    logic [LN_W-1:0]   mem_req_wline;
    logic              mem_rsp_valid = 1'b0;
    logic [LN_W-1:0]   mem_rsp_rline = '0;

    int n_checks = 0;
    int n_errors = 0;
    int rd_count = 0;
    int wb_count = 0;
    logic [LA_W-1:0]   last_wb_addr = '0;
    logic [LN_W-1:0]   mem_lines [NLINES];
    logic [DATA_W-1:0] shadow [NWORDS];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vc_cache u_vc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wline(mem_req_wline),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rline(mem_rsp_rline)
    );

    function automatic logic [DATA_W-1:0] pat(input int a);
        return 32'hA500_0000 ^ (a * 32'h0001_0003);
    endfunction

    // Next-level model: always ready, read data one cycle after the request.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem_lines[mem_req_addr] <= mem_req_wline;
                last_wb_addr <= mem_req_addr;
                wb_count <= wb_count + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rline <= mem_lines[mem_req_addr];
                rd_count <= rd_count + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Issue one request and measure edges from acceptance to response.
    task automatic do_op(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                         output int lat, output logic [DATA_W-1:0] rd, output int busy_bad);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        busy_bad = 0;
        @(posedge clk); lat = 1;
        @(negedge clk); req_valid = 1'b0;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) busy_bad++;
            @(posedge clk); lat++;
            @(negedge clk);
        end
        rd = rsp_rdata;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no response in reset", 64'(rsp_valid), 64'd0);
        check(mem_req_valid == 1'b0, "R1 no memory request in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int lat, busy, r0, w0;
        logic [DATA_W-1:0] rd, exp;
        string tag;
        for (int l = 0; l < NLINES; l++)
            for (int w = 0; w < (1 << OFF_W); w++)
                mem_lines[l][w*DATA_W +: DATA_W] = pat(l * (1 << OFF_W) + w);
        for (int a = 0; a < NWORDS; a++) shadow[a] = pat(a);

        reset_dut(); // R1

        for (int i = 0; i < NV; i++) begin
            r0 = rd_count; w0 = wb_count;
            do_op(VECS[i].we, VECS[i].addr, VECS[i].wdata, lat, rd, busy);
            exp = VECS[i].we ? VECS[i].wdata : shadow[VECS[i].addr];
            if (VECS[i].we) shadow[VECS[i].addr] = VECS[i].wdata;
            tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
            check(rd == exp, {tag, " data"}, 64'(rd), 64'(exp));
            check(lat == int'(VECS[i].lat), {tag, " latency"}, 64'(lat), 64'(VECS[i].lat));
            check(rd_count - r0 == int'(VECS[i].reads), {tag, " reads"}, 64'(rd_count - r0), 64'(VECS[i].reads));
            check(wb_count - w0 == int'(VECS[i].wbs), {tag, " writes"}, 64'(wb_count - w0), 64'(VECS[i].wbs));
            check(busy == 0, {"R9 ready low while busy ", tag}, 64'(busy), 64'd0);
        end

        // R8: the written-back line went to its own address with the written word.
        check(last_wb_addr == 10'h008, "R8 write-back address", 64'(last_wb_addr), 64'h8);
        check(mem_lines[8][2*DATA_W +: DATA_W] == 32'h5EED_0001, "R8 write-back data",
              64'(mem_lines[8][2*DATA_W +: DATA_W]), 64'h5EED0001);
        check(mem_lines[8][0 +: DATA_W] == pat(32), "R8 write-back untouched word",
              64'(mem_lines[8][0 +: DATA_W]), 64'(pat(32)));

        // R1: reset mid-run drops both structures, so a buffered line refetches.
        reset_dut();
        r0 = rd_count;
        do_op(1'b0, 12'h061, 32'h0, lat, rd, busy);
        check(lat == 5, "R1 latency after reset", 64'(lat), 64'd5);
        check(rd_count - r0 == 1, "R1 refetch after reset", 64'(rd_count - r0), 64'd1);
        check(rd == pat(12'h061), "R1 data after reset", 64'(rd), 64'(pat(12'h061)));
        // R2: the refetched line now hits in one cycle.
        do_op(1'b0, 12'h060, 32'h0, lat, rd, busy);
        check(lat == 1, "R2 hit after refill", 64'(lat), 64'd1);
        check(rd == pat(12'h060), "R2 hit data", 64'(rd), 64'(pat(12'h060)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule